// File: doc/BRIEF.md
# Five-Byte Motion Report Serial Transmitter

This block sends a short motion report over an asynchronous serial line, one bit for every tick pulse it receives. Each report has five bytes. The first is a header that carries the raw state of three active-low buttons. The other four are delta bytes in the order X, Y, X, Y. Each delta byte comes from an external clear-on-read accumulator. The accumulator is read, and zeroed, on the same clock edge that loads that byte into the shifter.

A report goes out only when an activity flag is pending, and starting a report clears that flag. If activity arrives while a report is being sent, the flag is held and a second report follows the first. The block also drives a strobe line that goes low for one clock at the start of every tick. In the intended system the tick period is about 0.8 ms, which is roughly 1200 baud. Line-level inversion and the line driver are outside this block.

Top module: `rpt_tx_top`

## Requirements
- R1: While reset is asserted and after it is released, `txd` and `strobe_n` are high, and neither `x_rd` nor `y_rd` pulses before the first tick.
- R2: Each byte takes 13 ticks. The first tick drives a low start bit. The next 8 ticks drive the data bits, least significant bit first. The last 4 ticks drive high stop bits.
- R3: The header byte has bit 7 set, bits 2..0 equal to `btn_n` (bit i is button i, low means pressed) and bits 6..3 clear. `btn_n` is sampled on the tick that starts the header.
- R4: After the header, the bytes go out in the order X, Y, X, Y. The read strobe for the matching axis (`x_rd` or `y_rd`) is high for exactly the one clock whose tick starts that byte. The byte is the accumulator input sampled on that edge. The reads happen at ticks 13, 26, 39 and 52 of the report.
- R5: A report starts only on a tick where activity is pending and no report is active. Starting a report clears the pending flag.
- R6: After the last stop bit of the fifth byte, the next tick leaves `txd` high. `txd` then stays high, with no accumulator reads, until activity is pending.
- R7: `strobe_n` is low for the one clock after each tick edge and high at all other times.
- R8: An `act` pulse during a report is held. A new report then starts at the tick right after the end tick of the current report (tick 66 counted from the first report's start).
- R9: Reset leaves activity pending, so the first tick after reset starts a report without any `act` pulse.
- R10: `txd` changes only on clock edges where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-clock bit-rate pulse |
| act | input | 1 | Activity pulse, sets the pending flag |
| btn_n | input | 3 | Active-low button states |
| x_rd | output | 1 | Read-and-clear strobe to the X accumulator |
| x_data | input | 8 | X accumulator value |
| y_rd | output | 1 | Read-and-clear strobe to the Y accumulator |
| y_data | input | 8 | Y accumulator value |
| txd | output | 1 | Serial data, idle high |
| strobe_n | output | 1 | Active-low per-tick strobe |

## Verification
Two situations are hard to reach from the ports. One is activity that arrives in the middle of a report. The other is an accumulator that fills again between the two reads of the same axis. The stimulus pulses `act` at tick 10 of a report and then expects a back-to-back report starting at tick 66. It also loads new random accumulator values at tick 30. At that point the first X byte has been drained but the second has not. The expected second X and Y bytes must therefore differ from the first pair. The stimulus also changes `btn_n` in the middle of the header, which shows the header was sampled only on its start tick.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

   typedef enum logic [1:0] {
      SLOT_HDR = 2'd0,
      SLOT_X   = 2'd1,
      SLOT_Y   = 2'd2
   } slot_e;

endpackage

// File: rtl/rpt_strobe.sv
module rpt_strobe #(
   parameter bit STROBE_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic strobe_n
);

   generate
      if (STROBE_REG) begin : g_reg
         logic strobe_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) strobe_q <= 1'b1;
            else        strobe_q <= ~tick;
         end
         assign strobe_n = strobe_q;

         // R7: the strobe is low in the cycle after a tick edge and high otherwise
         a_r7_strobe_low : assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !strobe_n);
         a_r7_strobe_high : assert property (@(posedge clk) disable iff (!rst_n)
            !tick |=> strobe_n);
      end else begin : g_comb
         assign strobe_n = ~tick;
      end
   endgenerate

endmodule

// File: rtl/rpt_shifter.sv
module rpt_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              load,
   input  logic              shift,
   input  logic [DATA_W-1:0] load_val,
   output logic              txd
);

   logic [DATA_W-1:0] sr_q;
   logic              txd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q  <= '1;
         txd_q <= 1'b1;
      end else if (tick) begin
         if (load) begin
            sr_q  <= load_val;
            txd_q <= 1'b0;
         end else if (shift) begin
            sr_q  <= {1'b1, sr_q[DATA_W-1:1]};
            txd_q <= sr_q[0];
         end else begin
            txd_q <= 1'b1;
         end
      end
   end

   assign txd = txd_q;

   // R10: the line only moves on tick edges
   a_r10_txd_stable : assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(txd));
   // R2: a byte load drives the start bit low
   a_r2_start_low : assert property (@(posedge clk) disable iff (!rst_n)
      (tick && load) |=> !txd);
   // R6: a tick with neither load nor shift keeps the line high
   a_r6_idle_high : assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && !shift) |=> txd);

endmodule

// File: rtl/rpt_seq.sv
module rpt_seq
   import rpt_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int STOP_TICKS  = 4,
   parameter int DELTA_BYTES = 4
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  tick,
   input  logic  act,
   output logic  load,
   output logic  shift,
   output slot_e slot,
   output logic  x_rd,
   output logic  y_rd
);

   localparam int SHIFTS = DATA_W + STOP_TICKS;
   localparam int CNT_W  = $clog2(SHIFTS + 1);
   localparam int IDX_W  = $clog2(DELTA_BYTES + 1);

   // control word: upper field is the byte index, lower field the shift count
   typedef struct packed {
      logic [IDX_W-1:0] idx;
      logic [CNT_W-1:0] cnt;
   } ctl_t;

   ctl_t ctl_q;
   logic busy_q;
   logic pend_q;

   logic             cnt_zero;
   logic             last_byte;
   logic             start_new;
   logic             next_byte;
   logic             finish;
   logic [IDX_W-1:0] load_idx;

   always_comb begin
      cnt_zero  = (ctl_q.cnt == '0);
      last_byte = (ctl_q.idx == IDX_W'(DELTA_BYTES));
      start_new = tick && !busy_q && pend_q;
      next_byte = tick && busy_q && cnt_zero && !last_byte;
      finish    = tick && busy_q && cnt_zero && last_byte;
      shift     = tick && busy_q && !cnt_zero;
      load      = start_new || next_byte;
      load_idx  = start_new ? '0 : IDX_W'(ctl_q.idx + 1'b1);
      if (load_idx == '0)  slot = SLOT_HDR;
      else if (load_idx[0]) slot = SLOT_X;
      else                 slot = SLOT_Y;
      x_rd = load && (slot == SLOT_X);
      y_rd = load && (slot == SLOT_Y);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         busy_q <= 1'b0;
         pend_q <= 1'b1;
      end else begin
         pend_q <= act || (pend_q && !start_new);
         if (start_new)   busy_q <= 1'b1;
         else if (finish) busy_q <= 1'b0;
         if (load) begin
            ctl_q.idx <= load_idx;
            ctl_q.cnt <= CNT_W'(SHIFTS);
         end else if (shift) begin
            ctl_q.cnt <= CNT_W'(ctl_q.cnt - 1'b1);
         end
      end
   end

   // R4: at most one accumulator is read per clock, and a read lasts one clock
   a_r4_rd_onehot : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({x_rd, y_rd}));
   a_r4_x_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      x_rd |=> !x_rd);
   a_r4_y_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      y_rd |=> !y_rd);
   // R5: starting a report consumes the pending flag
   a_r5_start_clears : assert property (@(posedge clk) disable iff (!rst_n)
      (start_new && !act) |=> !pend_q);
   // R5: no byte is loaded while idle without pending activity
   a_r5_no_spurious : assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && !pend_q) |-> !load);
   // R2: the shift count never exceeds one byte's worth
   a_r2_cnt_range : assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q.cnt <= CNT_W'(SHIFTS));

endmodule

// File: rtl/rpt_tx_top.sv
module rpt_tx_top
   import rpt_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int BTN_W       = 3,
   parameter int STOP_TICKS  = 4,
   parameter int DELTA_BYTES = 4,
   parameter bit STROBE_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              act,
   input  logic [BTN_W-1:0]  btn_n,
   output logic              x_rd,
   input  logic [DATA_W-1:0] x_data,
   output logic              y_rd,
   input  logic [DATA_W-1:0] y_data,
   output logic              txd,
   output logic              strobe_n
);

   generate
      if (BTN_W >= DATA_W) begin : g_bad_btn
         $error("BTN_W must leave room for the header marker bit");
      end
      if (STOP_TICKS < 1) begin : g_bad_stop
         $error("STOP_TICKS must be at least one");
      end
      if (DELTA_BYTES < 1) begin : g_bad_cnt
         $error("DELTA_BYTES must be at least one");
      end
   endgenerate

   logic              load;
   logic              shift;
   slot_e             slot;
   logic [DATA_W-1:0] header;
   logic [DATA_W-1:0] load_val;

   always_comb begin
      header             = '0;
      header[DATA_W-1]   = 1'b1;
      header[BTN_W-1:0]  = btn_n;
      case (slot)
         SLOT_X:  load_val = x_data;
         SLOT_Y:  load_val = y_data;
         default: load_val = header;
      endcase
   end

   rpt_seq #(
      .DATA_W      (DATA_W),
      .STOP_TICKS  (STOP_TICKS),
      .DELTA_BYTES (DELTA_BYTES)
   ) seq_i (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .act   (act),
      .load  (load),
      .shift (shift),
      .slot  (slot),
      .x_rd  (x_rd),
      .y_rd  (y_rd)
   );

   rpt_shifter #(
      .DATA_W (DATA_W)
   ) shf_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .load     (load),
      .shift    (shift),
      .load_val (load_val),
      .txd      (txd)
   );

   rpt_strobe #(
      .STROBE_REG (STROBE_REG)
   ) stb_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .strobe_n (strobe_n)
   );

endmodule

// File: tb/rpt_tx_top_tb_top.sv
module rpt_tx_top_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       act = 1'b0;
   logic [2:0] btn_n = 3'b111;
   logic       x_rd;
   logic       y_rd;
   logic [7:0] x_acc = 8'h00;
   logic [7:0] y_acc = 8'h00;
   logic       txd;
   logic       strobe_n;

   int checks = 0;
   int errors = 0;
   int x_reads = 0;
   int y_reads = 0;
   bit done = 0;

   always #4 clk = ~clk;

   always @(posedge clk) begin
      if (x_rd) x_reads++;
      if (y_rd) y_reads++;
   end

   rpt_tx_top dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .act      (act),
      .btn_n    (btn_n),
      .x_rd     (x_rd),
      .x_data   (x_acc),
      .y_rd     (y_rd),
      .y_data   (y_acc),
      .txd      (txd),
      .strobe_n (strobe_n)
   );

   task automatic check(input string req, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, actual, expected, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   function automatic logic exp_bit(input logic [7:0] fr [5], input int k);
      int j = k / 13;
      int p = k % 13;
      if (j >= 5) return 1'b1;
      if (p == 0) return 1'b0;
      if (p <= 8) return fr[j][p-1];
      return 1'b1;
   endfunction

   // one tick; afterwards the tick edge has passed and the clock is at a negedge
   task automatic do_tick();
      int xr0 = x_reads;
      int yr0 = y_reads;
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      check("R7 strobe low after tick", int'(strobe_n), 0);
      if (x_reads != xr0) x_acc = 8'h00;
      if (y_reads != yr0) y_acc = 8'h00;
   endtask

   task automatic gap();
      @(negedge clk);
      check("R7 strobe high between ticks", int'(strobe_n), 1);
      @(negedge clk);
   endtask

   task automatic pulse_act();
      @(negedge clk) act = 1'b1;
      @(negedge clk) act = 1'b0;
   endtask

   task automatic run_frame(input logic [2:0] b, input logic [7:0] a, input logic [7:0] c,
                            input logic [7:0] bb, input logic [7:0] d, input bit mid_act);
      logic [7:0] fr [5];
      int xr0 = x_reads;
      int yr0 = y_reads;
      fr[0] = 8'h80 | {5'b0, b};
      fr[1] = a;
      fr[2] = c;
      fr[3] = bb;
      fr[4] = d;
      btn_n = b;
      x_acc = a;
      y_acc = c;
      for (int k = 0; k <= 65; k++) begin
         if (k == 3) btn_n = ~b;          // R3: header already sampled
         if (k == 10 && mid_act) pulse_act();
         if (k == 30) begin
            x_acc = bb;
            y_acc = d;
         end
         do_tick();
         if (k == 0 || (k % 13) == 0 && k < 65)
            check("R2/R3 start bit", int'(txd), 0);
         else
            check((k < 13) ? "R3 header bit" : (k == 65) ? "R6 end tick high" : "R2/R4 data bit",
                  int'(txd), int'(exp_bit(fr, k)));
         check("R4 x read timing", x_reads - xr0, (k >= 39) ? 2 : (k >= 13) ? 1 : 0);
         check("R4 y read timing", y_reads - yr0, (k >= 52) ? 2 : (k >= 26) ? 1 : 0);
         gap();
      end
   endtask

   task automatic idle_ticks(input int n);
      int xr0 = x_reads;
      int yr0 = y_reads;
      for (int i = 0; i < n; i++) begin
         do_tick();
         check("R6/R5 idle line high", int'(txd), 1);
         gap();
      end
      check("R5 no reads while idle", (x_reads - xr0) + (y_reads - yr0), 0);
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      check("R1 txd high in reset", int'(txd), 1);
      check("R1 strobe high in reset", int'(strobe_n), 1);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 txd high after reset", int'(txd), 1);
      check("R1 strobe high after reset", int'(strobe_n), 1);
      check("R1 no reads before tick", x_reads + y_reads, 0);

      // R9: report from reset-pending flag, no act pulse
      run_frame(3'b101, 8'h3C, 8'hC3, 8'h01, 8'h80, 1'b0);
      idle_ticks(6);

      // directed corners: all pressed, none pressed, extreme deltas
      pulse_act();
      run_frame(3'b000, 8'hFF, 8'h00, 8'h00, 8'hFF, 1'b0);
      idle_ticks(2);
      pulse_act();
      run_frame(3'b111, 8'h00, 8'hFF, 8'hAA, 8'h55, 1'b0);
      idle_ticks(2);

      // R8: activity during a report gives a back-to-back report
      pulse_act();
      run_frame(3'b011, 8'h12, 8'h34, 8'h56, 8'h78, 1'b1);
      run_frame(3'b110, 8'h9A, 8'hBC, 8'hDE, 8'hF0, 1'b0);
      idle_ticks(4);

      // random reports
      for (int n = 0; n < 8; n++) begin
         pulse_act();
         run_frame(3'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                   ($urandom % 3) == 0);
         if (txd == 1'b1 && n == 7) idle_ticks(70);
      end
      idle_ticks(70);
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule